// File: doc/BRIEF.md
# Resistive Touchscreen Scan Sequencer

This block scans a 4-wire resistive touch panel on its own, paced by a slow timebase tick. For every coordinate pair it runs a fixed sequence of phases. It lets the panel settle, converts the X axis, settles again, and converts the Y axis. It then samples the pen comparator, waits a touch-detect interval, and waits an update interval. Each timed phase lasts a number of ticks taken from a register. Conversions use an external converter through a start/done handshake that returns a 10-bit code.

Each finished pair is reduced to the programmed resolution and checked against a rectangular acceptance window. If it passes, it is packed with the pen level into one 32-bit word and pushed into a small result FIFO. An interrupt stays high while the FIFO holds at least a set number of words. Software controls the block and drains the results through a simple register port, where each read of the data register pops one word.

Top module: `ts_scan_top`

## Requirements
- R1: After reset the status register reads 0x80 (empty flag bit 7 set, overrun bit 8 clear), the control register reads 0, and `irq` is low.
- R2: Phase order is settle, X conversion, settle, Y conversion, pen detect, touch detect, update. Between the done of an X conversion and the next start there are exactly `settle` ticks. Between the done of a Y conversion and the next X start there are `pen + touch + update + settle` ticks. A programmed count of 0 acts as 1.
- R3: `conv_start` is high for exactly one clock. `conv_chan` is 0 for X and 1 for Y and holds while a conversion is pending. The block leaves a conversion phase only on `conv_done`, and starts alternate X, Y beginning with X.
- R4: A FIFO word holds the pen level in bit 31, X in bits 25:16 and Y in bits 9:0, and all other bits are 0. The pen level is the inverse of `pen_touch` sampled at the end of pen detect, so 0 means the pen is down.
- R5: Control bits 9:7 (X) and 6:4 (Y) hold a resolution field n. The low n bits of that axis result are cleared, and n = 0 keeps all 10 bits.
- R6: A pair is stored only if xmin <= X <= xmax and ymin <= Y <= ymax, using the values after resolution. Window registers keep only 10 bits of a write.
- R7: Each read of the data register pops one word in arrival order. A read while the FIFO is empty returns 0 and changes no state.
- R8: `irq` is high while the FIFO holds at least IRQ_LEVEL (default 4) words and low otherwise.
- R9: A word arriving while the FIFO is full is dropped and sets the overrun flag (status bit 8). The flag stays set until the FIFO has been drained empty.
- R10: Scanning starts only when control bit 0 (enable) and bit 2 (power) are both set. Clearing bit 0 stops the sequence at the end of the current phase, and no further conversion starts.
- R11: Register word addresses are 0 status, 1 control, 2 data, 3 settle, 4 pen detect, 5 touch detect, 6 update, 7 xmin, 8 xmax, 9 ymin, 10 ymax. Read data appears in the clock after the read strobe. The timing registers reset to 2, 4, 16 and 88, and the window resets to 0..0x3FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-clock timebase pulse (slow tick) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the clock after `reg_rd` |
| irq | output | 1 | FIFO fill-level interrupt |
| conv_start | output | 1 | One-clock converter start |
| conv_chan | output | 1 | Converter channel, 0 = X, 1 = Y |
| conv_done | input | 1 | Converter result ready |
| conv_code | input | 10 | Converter result code |
| pen_touch | input | 1 | Panel comparator, high while touched |

## Verification
The hardest state to reach is overrun followed by a partial drain. The FIFO has to fill, a further accepted pair has to arrive, and scanning has to stop before anything is read. The stimulus leaves scanning enabled until the bench's converter model has handed out six accepted pairs and only then clears the enable bit. It then pops one word at a time and checks that the flag survives three pops and clears on the fourth. The tick-exact phase lengths are measured by counting ticks between converter done and the next start. Resolution is swept over all eight field values.

// File: rtl/ts_scan_pkg.sv
package ts_scan_pkg;

  localparam int CODE_W = 10;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETTLE_X,
    PH_CONV_X,
    PH_SETTLE_Y,
    PH_CONV_Y,
    PH_PEN,
    PH_TOUCH,
    PH_UPDATE
  } phase_e;

  // register word addresses
  localparam logic [3:0] A_STATUS = 4'd0;
  localparam logic [3:0] A_CTRL   = 4'd1;
  localparam logic [3:0] A_DATA   = 4'd2;
  localparam logic [3:0] A_SETTLE = 4'd3;
  localparam logic [3:0] A_PEN    = 4'd4;
  localparam logic [3:0] A_TOUCH  = 4'd5;
  localparam logic [3:0] A_UPDATE = 4'd6;
  localparam logic [3:0] A_XMIN   = 4'd7;
  localparam logic [3:0] A_XMAX   = 4'd8;
  localparam logic [3:0] A_YMIN   = 4'd9;
  localparam logic [3:0] A_YMAX   = 4'd10;

  typedef struct packed {
    logic              pen_up;
    logic [CODE_W-1:0] x;
    logic [CODE_W-1:0] y;
  } sample_t;

endpackage

// File: rtl/ts_scan_seq.sv
module ts_scan_seq
  import ts_scan_pkg::*;
#(
  parameter int TW = 8,
  parameter int CW = CODE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          scan_en,
  input  logic          pwr_en,
  input  logic [TW-1:0] settle_t,
  input  logic [TW-1:0] pen_t,
  input  logic [TW-1:0] touch_t,
  input  logic [TW-1:0] upd_t,
  input  logic [2:0]    xres,
  input  logic [2:0]    yres,
  input  logic          conv_done,
  input  logic [CW-1:0] conv_code,
  input  logic          pen_touch,
  output logic          conv_start,
  output logic          conv_chan,
  output logic          push_vld,
  output sample_t       push_smp
);

  phase_e        phase_q, nxt_ph;
  logic [TW-1:0] tcnt_q, lim;
  logic          issued_q, start_q, chan_q, push_q, pen_q;
  logic [CW-1:0] x_q, y_q, xmask, ymask;
  logic          last_tick;

  assign xmask = {CW{1'b1}} << xres;
  assign ymask = {CW{1'b1}} << yres;

  always_comb begin
    case (phase_q)
      PH_SETTLE_X, PH_SETTLE_Y: lim = settle_t;
      PH_PEN:                   lim = pen_t;
      PH_TOUCH:                 lim = touch_t;
      default:                  lim = upd_t;
    endcase
  end

  // zero behaves as one tick
  assign last_tick = ({1'b0, tcnt_q} + 1'b1) >= {1'b0, lim};

  always_comb begin
    case (phase_q)
      PH_SETTLE_X: nxt_ph = PH_CONV_X;
      PH_CONV_X:   nxt_ph = PH_SETTLE_Y;
      PH_SETTLE_Y: nxt_ph = PH_CONV_Y;
      PH_CONV_Y:   nxt_ph = PH_PEN;
      PH_PEN:      nxt_ph = PH_TOUCH;
      PH_TOUCH:    nxt_ph = PH_UPDATE;
      default:     nxt_ph = PH_SETTLE_X;
    endcase
    if (phase_q == PH_UPDATE) begin
      if (!(scan_en && pwr_en)) nxt_ph = PH_IDLE;
    end else if (!scan_en) begin
      nxt_ph = PH_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_IDLE;
      tcnt_q   <= '0;
      issued_q <= 1'b0;
      start_q  <= 1'b0;
      chan_q   <= 1'b0;
      push_q   <= 1'b0;
      pen_q    <= 1'b1;
      x_q      <= '0;
      y_q      <= '0;
    end else begin
      start_q <= 1'b0;
      push_q  <= 1'b0;
      case (phase_q)
        PH_IDLE: begin
          tcnt_q <= '0;
          if (scan_en && pwr_en) phase_q <= PH_SETTLE_X;
        end
        PH_CONV_X, PH_CONV_Y: begin
          if (!issued_q) begin
            start_q  <= 1'b1;
            issued_q <= 1'b1;
            chan_q   <= (phase_q == PH_CONV_Y);
          end else if (conv_done) begin
            issued_q <= 1'b0;
            tcnt_q   <= '0;
            if (phase_q == PH_CONV_X) x_q <= conv_code & xmask;
            else                      y_q <= conv_code & ymask;
            phase_q  <= nxt_ph;
          end
        end
        default: begin
          if (tick) begin
            if (last_tick) begin
              tcnt_q  <= '0;
              phase_q <= nxt_ph;
              if (phase_q == PH_PEN)   pen_q  <= ~pen_touch;
              if (phase_q == PH_TOUCH) push_q <= 1'b1;
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
        end
      endcase
    end
  end

  assign conv_start = start_q;
  assign conv_chan  = chan_q;
  assign push_vld   = push_q;
  assign push_smp   = '{pen_up: pen_q, x: x_q, y: y_q};

  AST_START_ONE: assert property (@(posedge clk) disable iff (rst)
    start_q |=> !start_q); // R3
  AST_CHAN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (issued_q && !conv_done) |=> $stable(chan_q)); // R3

endmodule

// File: rtl/ts_scan_fifo.sv
module ts_scan_fifo #(
  parameter int DW    = 21,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic [DW-1:0]                push_data,
  input  logic                         pop,
  output logic [DW-1:0]                pop_data,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         overrun
);

  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [DW-1:0]    mem [DEPTH];
  logic [AW-1:0]    wp_q, rp_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DW-1:0]    rd_q;
  logic             ovr_q, pop_ok, wr_ok;

  assign pop_ok = pop && (cnt_q != '0);
  assign wr_ok  = push && ((cnt_q != CNT_W'(DEPTH)) || pop_ok);

  always_comb begin
    cnt_d = cnt_q;
    if (wr_ok && !pop_ok)      cnt_d = cnt_q + 1'b1;
    else if (pop_ok && !wr_ok) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp_q] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      rd_q  <= '0;
      ovr_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (wr_ok) wp_q <= (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
      if (pop) begin
        rd_q <= pop_ok ? mem[rp_q] : '0;
        if (pop_ok) rp_q <= (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
      end
      if (push && !wr_ok)    ovr_q <= 1'b1;
      else if (cnt_d == '0)  ovr_q <= 1'b0;
    end
  end

  assign pop_data = rd_q;
  assign count    = cnt_q;
  assign overrun  = ovr_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(DEPTH)); // R9
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovr_q && !pop) |=> ovr_q); // R9
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
    (pop && cnt_q == '0 && !push) |=> (cnt_q == '0)); // R7

endmodule

// File: rtl/ts_scan_top.sv
module ts_scan_top
  import ts_scan_pkg::*;
#(
  parameter int TW        = 8,
  parameter int DEPTH     = 4,
  parameter int IRQ_LEVEL = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        conv_start,
  output logic        conv_chan,
  input  logic        conv_done,
  input  logic [9:0]  conv_code,
  input  logic        pen_touch
);

  localparam int CW    = CODE_W;
  localparam int DW    = $bits(sample_t);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [9:0]    ctrl_q;
  logic [TW-1:0] settle_q, pen_q, touch_q, upd_q;
  logic [CW-1:0] xmin_q, xmax_q, ymin_q, ymax_q;
  logic [31:0]   rdata_q;
  logic          sel_fifo_q, irq_q;

  logic          push_vld, in_win, fifo_pop, ovr;
  sample_t       push_smp, head;
  logic [DW-1:0] head_raw;
  logic [CNT_W-1:0] fifo_cnt;

  ts_scan_seq #(.TW(TW), .CW(CW)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .scan_en   (ctrl_q[0]),
    .pwr_en    (ctrl_q[2]),
    .settle_t  (settle_q),
    .pen_t     (pen_q),
    .touch_t   (touch_q),
    .upd_t     (upd_q),
    .xres      (ctrl_q[9:7]),
    .yres      (ctrl_q[6:4]),
    .conv_done (conv_done),
    .conv_code (conv_code),
    .pen_touch (pen_touch),
    .conv_start(conv_start),
    .conv_chan (conv_chan),
    .push_vld  (push_vld),
    .push_smp  (push_smp)
  );

  assign in_win = (push_smp.x >= xmin_q) && (push_smp.x <= xmax_q) &&
                  (push_smp.y >= ymin_q) && (push_smp.y <= ymax_q);
  assign fifo_pop = reg_rd && (reg_addr == A_DATA);

  ts_scan_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst      (rst),
    .push     (push_vld && in_win),
    .push_data(push_smp),
    .pop      (fifo_pop),
    .pop_data (head_raw),
    .count    (fifo_cnt),
    .overrun  (ovr)
  );

  assign head = head_raw;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      settle_q <= TW'(2);
      pen_q    <= TW'(4);
      touch_q  <= TW'(16);
      upd_q    <= TW'(88);
      xmin_q   <= '0;
      xmax_q   <= '1;
      ymin_q   <= '0;
      ymax_q   <= '1;
    end else if (reg_wr) begin
      case (reg_addr)
        A_CTRL:   ctrl_q   <= reg_wdata[9:0];
        A_SETTLE: settle_q <= reg_wdata[TW-1:0];
        A_PEN:    pen_q    <= reg_wdata[TW-1:0];
        A_TOUCH:  touch_q  <= reg_wdata[TW-1:0];
        A_UPDATE: upd_q    <= reg_wdata[TW-1:0];
        A_XMIN:   xmin_q   <= reg_wdata[CW-1:0];
        A_XMAX:   xmax_q   <= reg_wdata[CW-1:0];
        A_YMIN:   ymin_q   <= reg_wdata[CW-1:0];
        A_YMAX:   ymax_q   <= reg_wdata[CW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q    <= '0;
      sel_fifo_q <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      irq_q <= (fifo_cnt >= CNT_W'(IRQ_LEVEL));
      if (reg_rd) begin
        sel_fifo_q <= (reg_addr == A_DATA);
        case (reg_addr)
          A_STATUS: rdata_q <= {23'd0, ovr, (fifo_cnt == '0), 7'd0};
          A_CTRL:   rdata_q <= {22'd0, ctrl_q};
          A_SETTLE: rdata_q <= 32'(settle_q);
          A_PEN:    rdata_q <= 32'(pen_q);
          A_TOUCH:  rdata_q <= 32'(touch_q);
          A_UPDATE: rdata_q <= 32'(upd_q);
          A_XMIN:   rdata_q <= 32'(xmin_q);
          A_XMAX:   rdata_q <= 32'(xmax_q);
          A_YMIN:   rdata_q <= 32'(ymin_q);
          A_YMAX:   rdata_q <= 32'(ymax_q);
          default:  rdata_q <= '0;
        endcase
      end
    end
  end

  assign reg_rdata = sel_fifo_q ? {head.pen_up, 5'd0, head.x, 6'd0, head.y} : rdata_q;
  assign irq       = irq_q;

  AST_IRQ_TRACK: assert property (@(posedge clk) disable iff (rst)
    (fifo_cnt >= CNT_W'(IRQ_LEVEL)) |=> irq_q); // R8
  AST_WIN_DROP: assert property (@(posedge clk) disable iff (rst)
    (push_vld && !in_win && !fifo_pop) |=> $stable(fifo_cnt)); // R6

endmodule

// File: tb/ts_scan_top_bench.sv
module ts_scan_top_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, conv_start, conv_chan;
  logic        conv_done = 1'b0;
  logic [9:0]  conv_code = '0;
  logic        pen_touch = 1'b0;

  int n_chk = 0, n_bad = 0;

  ts_scan_top u_ts_scan_top (
    .clk(clk), .rst(rst), .tick(tick), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .conv_start(conv_start), .conv_chan(conv_chan),
    .conv_done(conv_done), .conv_code(conv_code), .pen_touch(pen_touch)
  );

  always #4 clk = ~clk;

  // bench copies of programmed values
  int xres = 0, yres = 0;
  int wxmin = 0, wxmax = 1023, wymin = 0, wymax = 1023;

  // expected FIFO model
  logic [31:0] expq [0:255];
  int exp_wr = 0, exp_rd = 0, mcnt = 0, acc_total = 0;
  bit movr = 0;

  // converter / monitor state
  int n_start = 0, nconv = 0, delay = 0, ticks_since = 0, div = 0;
  int meas_xy = -1, meas_yx = -1, proto_err = 0;
  bit busy = 0, prev_start = 0, lv = 0, last_chan = 1, want_y = 0;
  bit chan_l = 0;
  logic [9:0] lastx = '0;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic pop_chk(input string rq);
    logic [31:0] d;
    rd(4'd2, d);
    if (mcnt > 0) begin
      chk(d == expq[exp_rd], rq, d, expq[exp_rd]);
      exp_rd++; mcnt--;
      if (mcnt == 0) movr = 0;
    end else begin
      chk(d == 32'd0, rq, d, 32'd0);
    end
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // enable with given fields, run until irq, then stop scanning
  task automatic run_to_irq(input logic [31:0] ctl);
    int guard;
    lv = 0;
    wr(4'd1, ctl | 32'h5);
    guard = 0;
    while (!irq && guard < 20000) begin @(negedge clk); guard++; end
    wr(4'd1, ctl & ~32'h1);
    wait_cycles(200);
  endtask

  // converter model, tick source and protocol monitor
  initial begin
    forever begin
      @(negedge clk);
      if (conv_done) ticks_since = 0;
      else if (tick) ticks_since++;
      if (conv_start) begin
        n_start++;
        if (prev_start) proto_err++;            // R3 one-clock pulse
        if (busy) proto_err++;                  // R3 no start while pending
        if (conv_chan != want_y) proto_err++;   // R3 X then Y
        if (lv && conv_chan && !last_chan) meas_xy = ticks_since;
        if (lv && !conv_chan && last_chan) meas_yx = ticks_since;
        busy = 1; delay = 3; chan_l = conv_chan;
      end
      prev_start = conv_start;
      conv_done = 1'b0;
      if (busy) begin
        delay--;
        if (delay == 0) begin
          logic [9:0] c, xm, ym;
          busy = 0;
          c = 10'((nconv * 389 + 71) % 1024);
          nconv++;
          conv_done = 1'b1; conv_code = c;
          last_chan = chan_l; want_y = !chan_l;
          if (!chan_l) lastx = c;
          else begin
            xm = lastx & (10'h3FF << xres);
            ym = c & (10'h3FF << yres);
            if (xm >= wxmin && xm <= wxmax && ym >= wymin && ym <= wymax) begin
              acc_total++;
              if (mcnt < 4) begin
                expq[exp_wr] = {~pen_touch, 5'd0, xm, 6'd0, ym};
                exp_wr++; mcnt++;
              end else movr = 1;
            end
          end
        end
      end
      tick = (div == 3);
      div = (div + 1) % 4;
      if (!busy && !conv_done && !conv_start && lv == 0) lv = 1;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int s0, base;
    wait_cycles(5);
    rst = 1'b0;
    wait_cycles(2);

    // R1 reset state
    rd(4'd0, d); chk(d == 32'h80, "R1 status", d, 32'h80);
    rd(4'd1, d); chk(d == 32'h0, "R1 ctrl", d, 32'h0);
    chk(irq == 1'b0, "R1 irq", 32'(irq), 32'h0);

    // R11 defaults
    rd(4'd3, d); chk(d == 32'd2, "R11 settle default", d, 32'd2);
    rd(4'd4, d); chk(d == 32'd4, "R11 pen default", d, 32'd4);
    rd(4'd5, d); chk(d == 32'd16, "R11 touch default", d, 32'd16);
    rd(4'd6, d); chk(d == 32'd88, "R11 update default", d, 32'd88);
    rd(4'd10, d); chk(d == 32'h3FF, "R11 ymax default", d, 32'h3FF);

    // R6 window registers keep 10 bits
    wr(4'd8, 32'h0000_FFFF);
    rd(4'd8, d); chk(d == 32'h3FF, "R6 xmax width", d, 32'h3FF);
    wr(4'd7, 32'h0000_F001);
    rd(4'd7, d); chk(d == 32'h001, "R6 xmin width", d, 32'h001);
    wr(4'd7, 32'h0);

    // faster timing
    wr(4'd3, 32'd3); wr(4'd4, 32'd2); wr(4'd5, 32'd3); wr(4'd6, 32'd5);

    // R10 power bit required
    wr(4'd1, 32'h1);
    wait_cycles(300);
    chk(n_start == 0, "R10 no scan without power", 32'(n_start), 32'd0);
    wr(4'd1, 32'h0);

    // main run, pen down
    pen_touch = 1'b1;
    run_to_irq(32'h0);
    chk(irq == 1'b1, "R8 irq at level", 32'(irq), 32'h1);
    rd(4'd0, d); chk(d == 32'h0, "R9 full no overrun", d, 32'h0);
    s0 = n_start;
    wait_cycles(300);
    chk(n_start == s0, "R10 stopped after enable clear", 32'(n_start), 32'(s0));
    chk(meas_xy == 3, "R2 settle before Y", 32'(meas_xy), 32'd3);
    chk(meas_yx == 13, "R2 pen+touch+update+settle", 32'(meas_yx), 32'd13);
    pop_chk("R7 R4 word 0");
    wait_cycles(2);
    chk(irq == 1'b0, "R8 irq below level", 32'(irq), 32'h0);
    for (int i = 1; i < 4; i++) pop_chk("R7 R4 word");
    rd(4'd0, d); chk(d == 32'h80, "R7 empty after drain", d, 32'h80);
    pop_chk("R7 pop empty");
    rd(4'd0, d); chk(d == 32'h80, "R7 status unchanged", d, 32'h80);

    // R5 resolution sweep, alternating pen level (R4)
    for (int xr = 0; xr < 8; xr++) begin
      xres = xr; yres = 7 - xr;
      pen_touch = xr[0];
      run_to_irq(32'(xr << 7) | 32'((7 - xr) << 4));
      for (int i = 0; i < 4; i++) pop_chk("R5 R4 resolution word");
    end
    xres = 0; yres = 0;

    // R6 window filtering
    wxmin = 10'h080; wxmax = 10'h37F; wymin = 10'h100; wymax = 10'h2FF;
    wr(4'd7, 32'h080); wr(4'd8, 32'h37F); wr(4'd9, 32'h100); wr(4'd10, 32'h2FF);
    pen_touch = 1'b1;
    run_to_irq(32'h0);
    for (int i = 0; i < 4; i++) pop_chk("R6 windowed word");
    wxmin = 0; wxmax = 1023; wymin = 0; wymax = 1023;
    wr(4'd7, 32'h0); wr(4'd8, 32'h3FF); wr(4'd9, 32'h0); wr(4'd10, 32'h3FF);

    // R9 overrun
    base = acc_total;
    lv = 0;
    wr(4'd1, 32'h5);
    for (int g = 0; g < 20000 && acc_total < base + 6; g++) @(negedge clk);
    wr(4'd1, 32'h4);
    wait_cycles(300);
    rd(4'd0, d); chk(d == 32'h100, "R9 overrun set", d, 32'h100);
    for (int i = 0; i < 3; i++) pop_chk("R9 kept words");
    rd(4'd0, d); chk(d == 32'h100, "R9 overrun holds", d, 32'h100);
    pop_chk("R9 last word");
    rd(4'd0, d); chk(d == 32'h80, "R9 overrun cleared", d, 32'h80);

    // R3 handshake protocol
    chk(proto_err == 0, "R3 handshake", 32'(proto_err), 32'd0);
    chk(n_start > 0, "R3 conversions issued", 32'(n_start), 32'd1);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule